// File: doc/BRIEF.md
# Text Command Parser for Debug Register Access

This block sits between a serial receiver and a register-access engine that talks to a target's background debug logic. It takes one received character at a time and recognises single-letter commands. The case of the letter decides the direction: a capital letter asks for a read and a small letter asks for a write. The registers it can reach are the address, control, data and flag registers, plus a small bank of breakpoint registers chosen by a one-digit index. Numeric arguments arrive as hexadecimal characters, two per byte, with the high byte first.

Once a command is complete, the block raises a request on a ready/valid register port. It then waits for the response, which carries 16 bits of data and a short status code. Replies go out one character at a time to a serial transmitter, and only when the transmitter is ready. A successful read answers with the data and status as text. Any error answers with a framed error code.

Commands may follow each other on one line with no separator. Line-end characters between commands are skipped.

Top module: `dbgcmd_parser`

## Requirements
- R1: After reset, `rx_ready` is 1 and both `tx_valid` and `req_valid` are 0.
- R2: The opcodes `A`, `C`, `D` and `F` issue a read (`req_write`=0) with `req_sel` equal to 8, 9, 10 and 11 respectively. `B` followed by one hex digit i reads `req_sel`=i. A good read replies with the seven characters "XXYY:SS". XXYY is the response data in upper-case hex, most significant nibble first. SS is the status zero-extended to a byte, shown as two hex digits.
- R3: `a` and `d` followed by four hex digits write `req_sel` 8 and 10 respectively. `b` followed by an index digit and four hex digits writes `req_sel` equal to the index. The first digit pair is bits 15:8 of `req_wdata`. `c` followed by two hex digits writes `req_sel` 9 with `req_wdata[15:8]`=0. A write whose status is good sends no reply.
- R4: A breakpoint index digit of value 6 or more (BP_COUNT) replies "*ERR=B0*" and issues no request.
- R5: Any character in opcode position other than A a B b C c D d F N, CR (0x0D) or LF (0x0A) replies "*ERR=80*". Opcodes are case-exact, so `f`, `n` and `E` are unknown.
- R6: A non-hex character in an argument position replies "*ERR=90*". The command is dropped along with that character, and no request is issued.
- R7: CR or LF in an argument position replies "*ERR=A0*" and drops the command. CR and LF in opcode position produce no reply and no request.
- R8: A response whose status differs from EXP_STATUS (default 1) replies "*ERR=Cs*", where s is the status nibble. No data reply is sent in this case. This applies to both reads and writes.
- R9: Argument digits accept 0-9, A-F and a-f with equal meaning.
- R10: `N` produces no request and no reply.
- R11: Concatenated commands execute in order. Each reply finishes before the next character is accepted.
- R12: `req_valid` and its payload hold until `req_ready`. `tx_valid` and `tx_data` hold until `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received character present |
| rx_data | input | 8 | Received character |
| rx_ready | output | 1 | Parser accepts a character this cycle |
| req_valid | output | 1 | Register access request pending |
| req_ready | input | 1 | Access engine takes the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_sel | output | 4 | Register select: 0..5 breakpoints, 8 address, 9 control, 10 data, 11 flag |
| req_wdata | output | 16 | Write value |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Parser waits for a response |
| rsp_data | input | 16 | Read data |
| rsp_status | input | 4 | Status from the target port |
| tx_valid | output | 1 | Reply character present |
| tx_ready | input | 1 | Transmitter takes the character |
| tx_data | output | 8 | Reply character |

## Verification
The hardest case to reach from the ports is a reply held back by a stalled transmitter while more command characters are already waiting. The parser must keep the character stable and must not take new input until the reply has gone out. The bench reaches this in two ways. It throttles `tx_ready` and `req_ready` with a pseudo-random pattern throughout. In one test it also holds the transmitter off completely across a read and then checks that the first reply character is still presented unchanged. Error paths are reached by embedding bad digits, line ends and out-of-range indices in the middle of otherwise valid commands. A scoreboard then checks that the characters which follow are still parsed correctly.

// File: rtl/dbgcmd_pkg.sv
package dbgcmd_pkg;

    localparam int DATA_W = 16;
    localparam int SEL_W  = 4;

    localparam logic [SEL_W-1:0] SEL_ADDR = 4'h8;
    localparam logic [SEL_W-1:0] SEL_CTRL = 4'h9;
    localparam logic [SEL_W-1:0] SEL_DATA = 4'hA;
    localparam logic [SEL_W-1:0] SEL_FLAG = 4'hB;

    localparam logic [7:0] ERR_UNKNOWN = 8'h80;
    localparam logic [7:0] ERR_BADHEX  = 8'h90;
    localparam logic [7:0] ERR_SHORT   = 8'hA0;
    localparam logic [7:0] ERR_BPIDX   = 8'hB0;
    localparam logic [7:0] ERR_STATUS  = 8'hC0;

    typedef enum logic [1:0] {RK_NONE, RK_DATA, RK_ERR} reply_kind_e;

    typedef struct packed {
        reply_kind_e       kind;
        logic [DATA_W-1:0] data;
        logic [7:0]        stat;
        logic [7:0]        code;
    } reply_t;

    typedef struct packed {
        logic              write;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    typedef struct packed {
        logic             valid;
        logic             noop;
        logic             write;
        logic [SEL_W-1:0] sel;
        logic [2:0]       nibs;
        logic             has_index;
    } op_info_t;

    function automatic op_info_t decode_op(input logic [7:0] c);
        op_info_t o;
        o = '0;
        o.valid = 1'b1;
        case (c)
            "A": o.sel = SEL_ADDR;
            "a": begin o.sel = SEL_ADDR; o.write = 1'b1; o.nibs = 3'd4; end
            "C": o.sel = SEL_CTRL;
            "c": begin o.sel = SEL_CTRL; o.write = 1'b1; o.nibs = 3'd2; end
            "D": o.sel = SEL_DATA;
            "d": begin o.sel = SEL_DATA; o.write = 1'b1; o.nibs = 3'd4; end
            "F": o.sel = SEL_FLAG;
            "B": o.has_index = 1'b1;
            "b": begin o.has_index = 1'b1; o.write = 1'b1; o.nibs = 3'd4; end
            "N": o.noop = 1'b1;
            default: o.valid = 1'b0;
        endcase
        return o;
    endfunction

    function automatic logic [7:0] nib2ascii(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction

endpackage

// File: rtl/dbgcmd_lexer.sv
module dbgcmd_lexer (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nib,
    output logic       is_eol
);
    always_comb begin
        is_hex = 1'b1;
        nib    = 4'h0;
        if (ch >= "0" && ch <= "9")      nib = 4'(ch - 8'h30);
        else if (ch >= "A" && ch <= "F") nib = 4'(ch - 8'h37);
        else if (ch >= "a" && ch <= "f") nib = 4'(ch - 8'h57);
        else                             is_hex = 1'b0;
        is_eol = (ch == 8'h0D) || (ch == 8'h0A);
    end
endmodule

// File: rtl/dbgcmd_seq.sv
module dbgcmd_seq
    import dbgcmd_pkg::*;
#(
    parameter int               BP_COUNT   = 6,
    parameter int               STAT_W     = 4,
    parameter logic [STAT_W-1:0] EXP_STATUS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    input  logic              lx_hex,
    input  logic [3:0]        lx_nib,
    input  logic              lx_eol,
    output logic              req_valid,
    input  logic              req_ready,
    output reg_req_t          req_o,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [STAT_W-1:0] rsp_status,
    output logic              rep_start,
    output reply_t            rep_o,
    input  logic              rep_busy
);
    localparam logic [3:0] BP_LIM = 4'(BP_COUNT);

    typedef enum logic [1:0] {S_IDLE, S_ARG, S_REQ, S_RSP} state_e;

    state_e   st;
    reg_req_t cur;
    logic [2:0] rem;
    logic       idx_pend;
    op_info_t   op_w;
    logic       take;

    assign op_w      = decode_op(rx_data);
    assign rx_ready  = (st == S_IDLE || st == S_ARG) && !rep_busy && !rep_start;
    assign take      = rx_valid && rx_ready;
    assign req_valid = (st == S_REQ);
    assign req_o     = cur;
    assign rsp_ready = (st == S_RSP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            cur       <= '0;
            rem       <= '0;
            idx_pend  <= 1'b0;
            rep_start <= 1'b0;
            rep_o     <= '0;
        end else begin
            rep_start <= 1'b0;
            case (st)
                S_IDLE: if (take && !lx_eol) begin
                    if (!op_w.valid) begin
                        rep_start <= 1'b1;
                        rep_o     <= '{kind: RK_ERR, data: '0, stat: '0, code: ERR_UNKNOWN};
                    end else if (!op_w.noop) begin
                        cur.write <= op_w.write;
                        cur.sel   <= op_w.sel;
                        cur.wdata <= '0;
                        idx_pend  <= op_w.has_index;
                        rem       <= op_w.nibs + {2'b00, op_w.has_index};
                        st        <= (op_w.nibs == 3'd0 && !op_w.has_index) ? S_REQ : S_ARG;
                    end
                end
                S_ARG: if (take) begin
                    if (lx_eol || !lx_hex || (idx_pend && lx_nib >= BP_LIM)) begin
                        rep_start <= 1'b1;
                        rep_o     <= '{kind: RK_ERR, data: '0, stat: '0,
                                       code: lx_eol ? ERR_SHORT : (!lx_hex ? ERR_BADHEX : ERR_BPIDX)};
                        st        <= S_IDLE;
                    end else begin
                        if (idx_pend) begin
                            cur.sel  <= lx_nib;
                            idx_pend <= 1'b0;
                        end else begin
                            cur.wdata <= {cur.wdata[DATA_W-5:0], lx_nib};
                        end
                        rem <= rem - 3'd1;
                        if (rem == 3'd1) st <= S_REQ;
                    end
                end
                S_REQ: if (req_ready) st <= S_RSP;
                S_RSP: if (rsp_valid) begin
                    st <= S_IDLE;
                    if (rsp_status != EXP_STATUS) begin
                        rep_start <= 1'b1;
                        rep_o     <= '{kind: RK_ERR, data: '0, stat: '0,
                                       code: ERR_STATUS | 8'(rsp_status)};
                    end else if (!cur.write) begin
                        rep_start <= 1'b1;
                        rep_o     <= '{kind: RK_DATA, data: rsp_data, stat: 8'(rsp_status), code: '0};
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_o)); // R12
    AST_BP_RANGE: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_o.sel[SEL_W-1] |-> req_o.sel < BP_LIM); // R4
    AST_CTRL_BYTE: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_o.write && req_o.sel == SEL_CTRL |-> req_o.wdata[15:8] == 8'h00); // R3
    AST_FLAG_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_o.sel == SEL_FLAG |-> !req_o.write); // R2
    AST_NO_RX_DURING_REPLY: assert property (@(posedge clk) disable iff (rst)
        rep_busy |-> !rx_ready); // R11
endmodule

// File: rtl/dbgcmd_reply.sv
module dbgcmd_reply
    import dbgcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  reply_t     rep_i,
    output logic       busy,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready
);
    reply_t     rq;
    logic [3:0] pos;
    logic [3:0] last;

    assign tx_valid = busy;
    assign last     = (rq.kind == RK_ERR) ? 4'd7 : 4'd6;

    always_comb begin
        tx_data = 8'h3F;
        if (rq.kind == RK_ERR) begin
            case (pos)
                4'd0, 4'd7: tx_data = "*";
                4'd1:       tx_data = "E";
                4'd2, 4'd3: tx_data = "R";
                4'd4:       tx_data = "=";
                4'd5:       tx_data = nib2ascii(rq.code[7:4]);
                4'd6:       tx_data = nib2ascii(rq.code[3:0]);
                default:    tx_data = 8'h3F;
            endcase
        end else begin
            case (pos)
                4'd0: tx_data = nib2ascii(rq.data[15:12]);
                4'd1: tx_data = nib2ascii(rq.data[11:8]);
                4'd2: tx_data = nib2ascii(rq.data[7:4]);
                4'd3: tx_data = nib2ascii(rq.data[3:0]);
                4'd4: tx_data = ":";
                4'd5: tx_data = nib2ascii(rq.stat[7:4]);
                4'd6: tx_data = nib2ascii(rq.stat[3:0]);
                default: tx_data = 8'h3F;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            pos  <= '0;
            rq   <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                pos  <= '0;
                rq   <= rep_i;
            end
        end else if (tx_ready) begin
            if (pos == last) busy <= 1'b0;
            else             pos  <= pos + 4'd1;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R12
    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R11
endmodule

// File: rtl/dbgcmd_parser.sv
module dbgcmd_parser
    import dbgcmd_pkg::*;
#(
    parameter int               BP_COUNT   = 6,
    parameter int               STAT_W     = 4,
    parameter logic [STAT_W-1:0] EXP_STATUS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [SEL_W-1:0]  req_sel,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [STAT_W-1:0] rsp_status,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data
);
    logic       lx_hex, lx_eol, rep_start, rep_busy;
    logic [3:0] lx_nib;
    reg_req_t   req_s;
    reply_t     rep_s;

    assign req_write = req_s.write;
    assign req_sel   = req_s.sel;
    assign req_wdata = req_s.wdata;

    dbgcmd_lexer u_lex (
        .ch(rx_data), .is_hex(lx_hex), .nib(lx_nib), .is_eol(lx_eol)
    );

    dbgcmd_seq #(.BP_COUNT(BP_COUNT), .STAT_W(STAT_W), .EXP_STATUS(EXP_STATUS)) u_seq (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .lx_hex(lx_hex), .lx_nib(lx_nib), .lx_eol(lx_eol),
        .req_valid(req_valid), .req_ready(req_ready), .req_o(req_s),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_status(rsp_status),
        .rep_start(rep_start), .rep_o(rep_s), .rep_busy(rep_busy)
    );

    dbgcmd_reply u_rep (
        .clk(clk), .rst(rst), .start(rep_start), .rep_i(rep_s), .busy(rep_busy),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );
endmodule

// File: tb/dbgcmd_parser_bench.sv
module dbgcmd_parser_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ready;
    logic        req_valid, req_ready = 1'b0, req_write;
    logic [3:0]  req_sel;
    logic [15:0] req_wdata;
    logic        rsp_valid = 1'b0, rsp_ready;
    logic [15:0] rsp_data = 16'h0;
    logic [3:0]  rsp_status = 4'h0;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_data;

    always #10 clk = ~clk;

    dbgcmd_parser u_dbgcmd_parser (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_sel(req_sel), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_status(rsp_status),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
    );

    typedef struct {
        logic        write;
        logic [3:0]  sel;
        logic [15:0] wdata;
        logic [15:0] rdata;
        logic [3:0]  stat;
        string       tag;
    } exp_req_t;

    exp_req_t   req_q[$];
    logic [7:0] chr_q[$];
    string      chr_tag_q[$];
    int         n_chk = 0, n_bad = 0;
    logic       tx_stall = 1'b0;
    logic [15:0] lf = 16'hACE1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic exp_text(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) begin
            chr_q.push_back(s[i]);
            chr_tag_q.push_back(tag);
        end
    endtask

    task automatic exp_req(input logic w, input logic [3:0] sel, input logic [15:0] wd,
                           input logic [15:0] rd, input logic [3:0] st, input string tag);
        exp_req_t e;
        e.write = w; e.sel = sel; e.wdata = wd; e.rdata = rd; e.stat = st; e.tag = tag;
        req_q.push_back(e);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk); #1;
        rx_valid = 1'b1;
        rx_data  = b;
        do @(negedge clk); while (!rx_ready);
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (n < 3000 && !(req_q.size() == 0 && chr_q.size() == 0 && !tx_valid && !req_valid)) begin
            @(negedge clk);
            n++;
        end
        repeat (20) @(negedge clk);
    endtask

    // ready pattern generators
    initial forever begin
        @(posedge clk); #1;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        tx_ready  = !tx_stall && (lf[1:0] != 2'b00);
        req_ready = (lf[4:3] != 2'b00);
    end

    // transmit monitor
    initial forever begin
        @(negedge clk);
        if (!rst && tx_valid && tx_ready) begin
            if (chr_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R11 unexpected char act=%0h exp=none", tx_data);
            end else begin
                logic [7:0] e;
                string t;
                e = chr_q.pop_front();
                t = chr_tag_q.pop_front();
                check(t, {24'h0, tx_data}, {24'h0, e});
            end
        end
    end

    // register-port responder
    initial forever begin
        @(negedge clk);
        if (!rst && req_valid && req_ready) begin
            exp_req_t e;
            if (req_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R10 unexpected request act=%0h exp=none", {req_write, req_sel, req_wdata});
                e.rdata = 16'h0; e.stat = 4'h1;
            end else begin
                e = req_q.pop_front();
                check(e.tag, {11'h0, req_write, req_sel, req_wdata}, {11'h0, e.write, e.sel, e.wdata});
            end
            repeat (2) @(posedge clk);
            #1;
            rsp_valid  = 1'b1;
            rsp_data   = e.rdata;
            rsp_status = e.stat;
            do @(negedge clk); while (!rsp_ready);
            @(posedge clk); #1;
            rsp_valid = 1'b0;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=done");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
        check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
        check("R1 req_valid", {31'h0, req_valid}, 32'h0);

        // reads
        exp_req(0, 4'h8, 16'h0, 16'h12AB, 4'h1, "R2 A"); exp_text("12AB:01", "R2 A");
        send_str("A"); wait_idle();
        exp_req(0, 4'hB, 16'h0, 16'hBEEF, 4'h1, "R2 F"); exp_text("BEEF:01", "R2 F");
        send_str("F"); wait_idle();
        exp_req(0, 4'hA, 16'h0, 16'h0C3D, 4'h1, "R2 D"); exp_text("0C3D:01", "R2 D");
        send_str("D"); wait_idle();
        exp_req(0, 4'h3, 16'h0, 16'h0042, 4'h1, "R2 B3"); exp_text("0042:01", "R2 B3");
        send_str("B3"); wait_idle();

        // writes, mixed-case digits
        exp_req(1, 4'h8, 16'h5FC3, 16'h0, 4'h1, "R3 R9 a");
        send_str("a5fC3"); wait_idle();
        exp_req(1, 4'h9, 16'h007E, 16'h0, 4'h1, "R3 c");
        send_str("c7e"); wait_idle();
        exp_req(1, 4'hA, 16'h0001, 16'h0, 4'h1, "R3 d");
        send_str("d0001"); wait_idle();
        exp_req(1, 4'h5, 16'hABCD, 16'h0, 4'h1, "R3 b5");
        send_str("b5ABCD"); wait_idle();
        exp_req(1, 4'h0, 16'hABCD, 16'h0, 4'h1, "R9 b0");
        send_str("b0abcd"); wait_idle();

        // errors
        exp_text("*ERR=B0*", "R4 B6"); send_str("B6"); wait_idle();
        exp_text("*ERR=B0*", "R4 b9"); send_str("b9"); wait_idle();
        exp_text("*ERR=90*", "R6 BZ"); send_str("BZ"); wait_idle();
        exp_text("*ERR=80*", "R5 x"); send_str("x"); wait_idle();
        exp_text("*ERR=80*", "R5 f"); send_str("f"); wait_idle();
        exp_text("*ERR=80*", "R5 E"); send_str("E"); wait_idle();
        exp_text("*ERR=90*", "R6 a12G"); send_str("a12G"); wait_idle();
        exp_text("*ERR=A0*", "R7 a12cr"); send_str("a12\r"); wait_idle();
        send_str("\r\n"); wait_idle();
        send_str("N"); wait_idle();
        check("R7 R10 silent", {30'h0, tx_valid, req_valid}, 32'h0);

        // status mismatch
        exp_req(0, 4'h8, 16'h0, 16'h1234, 4'h5, "R8 A"); exp_text("*ERR=C5*", "R8 A");
        send_str("A"); wait_idle();
        exp_req(1, 4'h9, 16'h0011, 16'h0, 4'h3, "R8 c"); exp_text("*ERR=C3*", "R8 c");
        send_str("c11"); wait_idle();

        // concatenated commands
        exp_req(0, 4'h8, 16'h0, 16'h1111, 4'h1, "R11 A"); exp_text("1111:01", "R11 A");
        exp_req(0, 4'h9, 16'h0, 16'h00C5, 4'h1, "R11 C"); exp_text("00C5:01", "R11 C");
        exp_text("*ERR=80*", "R11 q");
        exp_req(0, 4'hB, 16'h0, 16'h8001, 4'h1, "R11 F"); exp_text("8001:01", "R11 F");
        send_str("AN\r\nCqF"); wait_idle();

        // transmitter stall
        tx_stall = 1'b1;
        exp_req(0, 4'hB, 16'h0, 16'h7E01, 4'h1, "R12 F"); exp_text("7E01:01", "R12 F");
        send_str("F");
        for (int i = 0; i < 200 && !tx_valid; i++) @(negedge clk);
        repeat (8) @(negedge clk);
        check("R12 held valid", {31'h0, tx_valid}, 32'h1);
        check("R12 held data", {24'h0, tx_data}, 32'h37);
        check("R12 rx blocked", {31'h0, rx_ready}, 32'h0);
        tx_stall = 1'b0;
        wait_idle();

        repeat (50) @(negedge clk);
        if (req_q.size() != 0 || chr_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R11 leftover act=%0d/%0d exp=0/0", req_q.size(), chr_q.size());
        end
        summary();
        $finish;
    end
endmodule